// File: doc/BRIEF.md
# Seeded Decimal Digit Sequencer

The block turns an 8-bit seed into a run of pseudo-random decimal digits. A load pulse captures the seed in a right-shifting register, clears the running digit to zero and points the write counter at the first slot. Each accepted step does three things. It takes the least significant seed bit as the control bit S and derives the next digit from S and the previous digit in modulo-10 arithmetic. It writes that digit into a four-slot, 4-bit result file. It shifts the seed right by one place.

The write counter wraps, so a full run of eight steps fills the file twice, and the last four digits remain in the file. After the eighth step the block raises a completion flag and ignores further steps until the next load. The seed register contents and all four slots are visible on the ports for observation.

Top module: `prng_digit_fill`

## Requirements
- R1: After reset, all four slots read 0, the seed view reads 0 and `done` is 1, so steps are ignored until a load.
- R2: A load captures `seed`, clears `done`, restarts the digit at 0 and the write slot at slot 0, and leaves the slot contents unchanged. Load takes priority over a simultaneous step.
- R3: Each accepted step shifts the seed view right by one and fills the most significant bit with 0. The bit leaving at bit 0 is the control bit S for that step.
- R4: When S is 1, the new digit is (previous + 7) mod 10, so previous 2 gives 9.
- R5: When S is 0, the new digit is (3 × previous) mod 10.
- R6: The first digit after a load is 7 when seed bit 0 is 1 and 0 when seed bit 0 is 0.
- R7: Accepted steps write slot 0, then 1, 2, 3, and then wrap to 0. Slot i sits at `slots[4i+3:4i]`.
- R8: `done` rises with the eighth accepted step after a load. While `done` is 1, steps change neither the slots nor the seed view.
- R9: Every slot always holds a value from 0 to 9.
- R10: Seed 8'hC3 yields 7, 4, 2, 6, 8, 4, 1, 8 and leaves `slots` = 16'h8148.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture seed and restart the run |
| seed | input | 8 | Seed value to load |
| step | input | 1 | Advance the run by one digit |
| slots | output | 16 | Four 4-bit result slots, slot 0 in the low nibble |
| seed_q | output | 8 | Current seed shift register contents |
| done | output | 1 | Run of eight steps complete |

## Verification
The hardest state to reach from the ports is the boundary around completion. The bench has to issue an extra step on the cycle right after the eighth step, and it also has to load while a step is held high. The bench drives steps back to back with no idle gap, so the ninth step lands exactly as `done` rises. It then issues more steps in that state and expects the slots and seed view to stay frozen. A load that arrives three steps into a run shows that the slot pointer and the running digit restart while the stale slot contents survive.

// File: rtl/prng_digit_fill.sv
module prng_digit_fill #(
  parameter int SEED_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEED_W-1:0] seed,
  input  logic              step,
  output logic [15:0]       slots,
  output logic [SEED_W-1:0] seed_q,
  output logic              done
);
  localparam int CW = $clog2(SEED_W + 1);

  logic [SEED_W-1:0] sreg;
  logic [3:0]        prev, nxt, plus7, x3;
  logic [4:0]        triple;
  logic [1:0]        ptr;
  logic [CW-1:0]     cnt;
  logic [15:0]       file_q;
  logic              fin;

  assign plus7  = (prev >= 4'd3) ? prev - 4'd3 : prev + 4'd7;
  assign triple = {prev, 1'b0} + {1'b0, prev};
  assign x3     = (triple >= 5'd20) ? 4'(triple - 5'd20)
                : (triple >= 5'd10) ? 4'(triple - 5'd10)
                : triple[3:0];
  assign nxt    = sreg[0] ? plus7 : x3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      prev   <= '0;
      ptr    <= '0;
      cnt    <= '0;
      fin    <= 1'b1;
      file_q <= '0;
    end else if (load) begin
      sreg <= seed;
      prev <= '0;
      ptr  <= '0;
      cnt  <= '0;
      fin  <= 1'b0;
    end else if (step && !fin) begin
      sreg               <= sreg >> 1;
      prev               <= nxt;
      file_q[ptr*4 +: 4] <= nxt;
      ptr                <= ptr + 2'd1;
      cnt                <= cnt + 1'b1;
      fin                <= (cnt == CW'(SEED_W - 1));
    end
  end

  assign slots  = file_q;
  assign seed_q = sreg;
  assign done   = fin;
endmodule

module prng_digit_fill_chk #(
  parameter int SEED_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic [SEED_W-1:0] seed,
  input logic              step,
  input logic [15:0]       slots,
  input logic [SEED_W-1:0] seed_q,
  input logic              done
);
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slots[3:0] <= 4'd9 && slots[7:4] <= 4'd9 && slots[11:8] <= 4'd9 && slots[15:12] <= 4'd9); // R9
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !done && seed_q == $past(seed) && slots == $past(slots)); // R2
  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && !done |=> seed_q == ($past(seed_q) >> 1)); // R3
  AST_IGNORE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && done |=> $stable(slots) && $stable(seed_q) && done); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> done); // R8
endmodule

bind prng_digit_fill prng_digit_fill_chk #(.SEED_W(SEED_W)) chk (
  .clk(clk), .rst_n(rst_n), .load(load), .seed(seed), .step(step),
  .slots(slots), .seed_q(seed_q), .done(done)
);

// File: tb/prng_digit_fill_test.sv
`timescale 1ns/1ps
module prng_digit_fill_test;
  logic clk = 0, rst_n = 0, load = 0, step = 0;
  logic [7:0]  seed = 0;
  logic [15:0] slots;
  logic [7:0]  seed_q;
  logic        done;
  int checks = 0, fails = 0;

  typedef struct packed {
    logic [15:0] s;
    logic [7:0]  q;
    logic        d;
    logic [7:0]  req;
  } item_t;
  item_t sb[$];

  logic [15:0] m_slots = 0;
  logic [7:0]  m_seed = 0;
  logic        m_done = 1;
  logic [3:0]  m_prev = 0;
  logic [1:0]  m_ptr = 0;
  int          m_cnt = 0;

  prng_digit_fill uut (.clk(clk), .rst_n(rst_n), .load(load), .seed(seed), .step(step),
                       .slots(slots), .seed_q(seed_q), .done(done));

  always #10 clk = ~clk;

  function automatic logic [3:0] next_digit(logic [3:0] f, logic s);
    return s ? 4'((f + 7) % 10) : 4'((f * 3) % 10);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(int req);
    item_t it;
    it.s = m_slots; it.q = m_seed; it.d = m_done; it.req = 8'(req);
    sb.push_back(it);
  endtask

  task automatic do_load(logic [7:0] v, logic with_step, int req);
    @(negedge clk);
    load = 1; seed = v; step = with_step;
    m_seed = v; m_prev = 0; m_ptr = 0; m_cnt = 0; m_done = 0;
    push(req);
  endtask

  task automatic do_step(int req);
    logic [3:0] d;
    @(negedge clk);
    load = 0; step = 1;
    if (!m_done) begin
      d = next_digit(m_prev, m_seed[0]);
      m_slots[m_ptr*4 +: 4] = d;
      m_ptr++;
      m_seed = m_seed >> 1;
      m_prev = d;
      m_cnt++;
      if (m_cnt == 8) m_done = 1;
    end
    push(req);
  endtask

  task automatic idle();
    @(negedge clk);
    load = 0; step = 0;
  endtask

  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      item_t e;
      string tag;
      e = sb.pop_front();
      tag = $sformatf("R%0d", e.req);
      check({tag, " slots"}, 32'(slots), 32'(e.s));
      check({tag, " seed_q"}, 32'(seed_q), 32'(e.q));
      check({tag, " done"}, 32'(done), 32'(e.d));
    end
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset slots", 32'(slots), 0);
    check("R1 reset seed_q", 32'(seed_q), 0);
    check("R1 reset done", 32'(done), 1);
    do_step(1);                       // R1: step ignored before any load
    idle();

    do_load(8'hC3, 1, 2);             // R2: load wins over step
    for (int i = 0; i < 8; i++) do_step(10); // R10, R4, R5, R6, R7, R3
    do_step(8);                       // R8: lands as done rises
    do_step(8);
    idle();
    @(negedge clk);
    check("R10 final slots", 32'(slots), 32'h8148);

    do_load(8'hFF, 0, 4);             // R4: 7,4,1,8,5,2,9,6 (2 -> 9)
    for (int i = 0; i < 8; i++) do_step(4);
    idle();
    check("R4 final slots", 32'(slots), 32'h6925);

    do_load(8'h00, 0, 6);             // R6: first digit 0 when bit 0 clear
    do_step(6);
    do_step(5);                       // R5
    idle();

    do_load(8'h5A, 0, 2);             // R2: restart mid-run keeps old slots
    do_step(5);
    do_step(6);
    do_step(7);
    do_load(8'h37, 0, 2);
    for (int i = 0; i < 8; i++) begin
      do_step(7);                     // R7: order and wrap
      if (i % 3 == 1) idle();
    end
    idle();
    do_step(8);
    idle();

    for (int k = 1; k < 12; k++) begin
      do_load(8'(k * 37 + 11), 0, 3);
      for (int i = 0; i < 9; i++) do_step(3); // R3, R9
      idle();
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule